// File: doc/BRIEF.md
# Half-Full Elastic Buffer for a Serial Link Receiver

This block sits on the receive path of a serial link's physical coding sublayer. Data arrives on the clock recovered from the line and leaves on the local reference clock. Both sides carry one 20-bit entry per cycle, which is two 10-bit symbols, and each symbol has its own control flag. The two clocks are nominally equal, in either the 250 MHz full-rate mode or the 125 MHz half-rate mode, but they drift apart by a small offset. The buffer absorbs that offset by adding or removing filler symbols inside skip ordered sets. The transmitter inserts these sets for exactly this purpose.

Occupancy is kept near the middle of a 16-entry store. The write and read pointers are not synchronised continuously. Instead, the write side flips a toggle each time its pointer steps onto the half-depth index. The read domain detects that toggle, takes a sample of its own pointer, and compares it with the value the pointer would have if the store were centred. If the reader is running ahead, one filler entry is repeated. If it is running behind, one filler entry is skipped. The correction is applied at the next skip ordered set that allows it.

Top module: `ebuf_half_full`

## Requirements
- R1: Every entry that is not a filler entry leaves the read side exactly once, unchanged, and in the order it was written. The three entries the write side stores after reset are discarded.
- R2: `rd_valid` stays low after reset until the write side has stored at least half the depth (8 entries). From the first high cycle onward it stays high on every read cycle.
- R3: Entry layout: bits [9:0] and `kflag[0]` form the earlier symbol, and bits [19:10] and `kflag[1]` form the later one. A symbol is the comma when its flag is 1 and its low byte is 0xBC. It is the skip symbol when its flag is 1 and its low byte is 0x1C. The two upper bits are ignored when matching. The adjustment unit is one filler entry, meaning an entry whose two symbols are both skip symbols.
- R4: When the read clock is faster than the write clock, filler entries are added, `skp_added` pulses, and `skp_removed` never pulses.
- R5: When the read clock is slower, filler entries are removed, `skp_removed` pulses, and `skp_added` never pulses.
- R6: When the two clocks have equal frequency, no entry is added or removed.
- R7: An ordered set starts at an entry holding a comma. At most one adjustment is made per ordered set.
- R8: A filler entry is removed only when the entry after it is also a filler entry, so every ordered set keeps at least one filler entry. A set with a single filler entry is never shortened.
- R9: An added entry is a copy of the filler entry being output. `skp_added` is high in the cycle of the first copy, and the copy follows in the next cycle.
- R10: Each status pulse lasts one read cycle, `skp_removed` coincides with the filler entry that is kept, and the two pulses are never high together.
- R11: The read pointer has a tolerance band around its nominal value. No correction is requested while the deviation stays inside the band. The band is ±1 entry in half-rate mode and ±2 entries in full-rate mode, so under the same drift the first addition comes later in full-rate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered write clock |
| wr_rst_n | input | 1 | Active-low reset, write domain |
| wr_data | input | 20 | Two symbols written per cycle |
| wr_kflag | input | 2 | Control flag per written symbol |
| rd_clk | input | 1 | Local read clock |
| rd_rst_n | input | 1 | Active-low reset, read domain |
| rate_full | input | 1 | 1 = full-rate mode, 0 = half-rate mode (selects the tolerance band) |
| rd_data | output | 20 | Two symbols read per cycle |
| rd_kflag | output | 2 | Control flag per read symbol |
| rd_valid | output | 1 | Read data is live (set once the store is half filled) |
| skp_added | output | 1 | One-cycle pulse: a filler entry was repeated |
| skp_removed | output | 1 | One-cycle pulse: a filler entry was skipped |

## Verification
The hardest case to reach from the ports is a removal request that meets a set too short to give up a filler entry. The pointer offset has to grow past the band before the set arrives, and the set must still hold only one filler entry. The stimulus gets there by running the read clock about 2.5 % slow for many sets made only of a comma entry and one filler entry. The offset builds up until a removal is pending, and the bench checks that nothing is removed and that no data is lost. The mode band is reached by applying the same fast-read drift in both modes and comparing the read cycle at which the first addition appears.

// File: rtl/ebuf_pkg.sv
package ebuf_pkg;
    localparam int SYM_W   = 10;
    localparam int NSYM    = 2;
    localparam int ENT_W   = SYM_W * NSYM;
    localparam logic [7:0] COMMA_BYTE = 8'hBC;
    localparam logic [7:0] FILL_BYTE  = 8'h1C;

    typedef struct packed {
        logic [NSYM-1:0]  k;
        logic [ENT_W-1:0] d;
    } ebuf_ent_t;

    function automatic logic sym_match(input logic [SYM_W-1:0] s, input logic kf,
                                       input logic [7:0] code);
        return kf && (s[7:0] == code);
    endfunction

    // every symbol of the entry is a filler symbol
    function automatic logic ent_is_fill(input ebuf_ent_t e);
        logic all_f;
        all_f = 1'b1;
        for (int i = 0; i < NSYM; i++) begin
            all_f &= sym_match(e.d[i*SYM_W +: SYM_W], e.k[i], FILL_BYTE);
        end
        return all_f;
    endfunction

    // any symbol of the entry is a comma
    function automatic logic ent_has_comma(input ebuf_ent_t e);
        logic any_c;
        any_c = 1'b0;
        for (int i = 0; i < NSYM; i++) begin
            any_c |= sym_match(e.d[i*SYM_W +: SYM_W], e.k[i], COMMA_BYTE);
        end
        return any_c;
    endfunction
endpackage

// File: rtl/ebuf_wr_side.sv
module ebuf_wr_side #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int HALF = DEPTH / 2
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    output logic          wr_en,
    output logic [AW-1:0] wr_ptr,
    output logic          half_tgl
);
    typedef struct packed {
        logic          live;
        logic [AW-1:0] ptr;
        logic          tgl;
    } wr_st_t;

    wr_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.live = 1'b1;
        if (st_q.live) begin
            st_d.ptr = st_q.ptr + AW'(1);
            // pointer steps onto the half-depth index: flip the marker
            if (st_q.ptr == AW'(HALF - 1)) begin
                st_d.tgl = ~st_q.tgl;
            end
        end
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en    = st_q.live;
    assign wr_ptr   = st_q.ptr;
    assign half_tgl = st_q.tgl;
endmodule

// File: rtl/ebuf_store.sv
module ebuf_store
    import ebuf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  ebuf_ent_t     wr_ent,
    input  logic [AW-1:0] rd_addr_a,
    input  logic [AW-1:0] rd_addr_b,
    output ebuf_ent_t     rd_ent_a,
    output ebuf_ent_t     rd_ent_b
);
    ebuf_ent_t mem_q [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_ent;
        end
    end

    assign rd_ent_a = mem_q[rd_addr_a];
    assign rd_ent_b = mem_q[rd_addr_b];
endmodule

// File: rtl/ebuf_tgl_sync.sv
module ebuf_tgl_sync #(
    parameter int STAGES = 2
) (
    input  logic rd_clk,
    input  logic rd_rst_n,
    input  logic tgl_in,
    output logic evt
);
    // STAGES synchroniser flops plus one history flop for the edge detector
    logic [STAGES:0] chain_q, chain_d;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], tgl_in};
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign evt = chain_q[STAGES] ^ chain_q[STAGES-1];
endmodule

// File: rtl/ebuf_rd_ctrl.sv
module ebuf_rd_ctrl
    import ebuf_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int REF_PTR   = 2,
    parameter int BAND_HALF = 1,
    parameter int BAND_FULL = 2,
    localparam int AW       = $clog2(DEPTH),
    localparam int START    = REF_PTR + 1
) (
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          evt,
    input  logic          rate_full,
    input  ebuf_ent_t     cur_ent,
    input  ebuf_ent_t     nxt_ent,
    output logic [AW-1:0] rd_ptr,
    output ebuf_ent_t     out_ent,
    output logic          out_vld,
    output logic          add_p,
    output logic          rem_p
);
    typedef struct packed {
        logic          run;
        logic [AW-1:0] ptr;
        logic          pend_add;
        logic          pend_del;
        logic          set_done;
        ebuf_ent_t     ent;
        logic          vld;
        logic          add;
        logic          rem;
    } rd_st_t;

    rd_st_t st_q, st_d;

    logic signed [AW-1:0] dev;
    int                   dev_i;
    int                   band;
    logic [1:0]           step;

    always_comb begin
        st_d     = st_q;
        st_d.add = 1'b0;
        st_d.rem = 1'b0;
        step     = 2'd1;
        dev      = signed'(st_q.ptr - AW'(REF_PTR));
        dev_i    = int'(dev);
        band     = rate_full ? BAND_FULL : BAND_HALF;

        if (!st_q.run) begin
            st_d.vld = 1'b0;
            if (evt) begin
                st_d.run = 1'b1;
                st_d.ptr = AW'(START);
            end
        end else begin
            st_d.vld = 1'b1;
            st_d.ent = cur_ent;
            if (ent_is_fill(cur_ent)) begin
                if (st_q.pend_add && !st_q.set_done) begin
                    step          = 2'd0;
                    st_d.add      = 1'b1;
                    st_d.pend_add = 1'b0;
                    st_d.set_done = 1'b1;
                end else if (st_q.pend_del && !st_q.set_done && ent_is_fill(nxt_ent)) begin
                    step          = 2'd2;
                    st_d.rem      = 1'b1;
                    st_d.pend_del = 1'b0;
                    st_d.set_done = 1'b1;
                end
            end else if (ent_has_comma(cur_ent)) begin
                st_d.set_done = 1'b0;
            end
            st_d.ptr = st_q.ptr + AW'(step);

            if (evt) begin
                st_d.pend_add = (dev_i > band);
                st_d.pend_del = (dev_i < -band);
            end
        end
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_ptr  = st_q.ptr;
    assign out_ent = st_q.ent;
    assign out_vld = st_q.vld;
    assign add_p   = st_q.add;
    assign rem_p   = st_q.rem;
endmodule

// File: rtl/ebuf_half_full.sv
module ebuf_half_full
    import ebuf_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int BAND_HALF   = 1,
    parameter int BAND_FULL   = 2,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic             wr_clk,
    input  logic             wr_rst_n,
    input  logic [ENT_W-1:0] wr_data,
    input  logic [NSYM-1:0]  wr_kflag,
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    input  logic             rate_full,
    output logic [ENT_W-1:0] rd_data,
    output logic [NSYM-1:0]  rd_kflag,
    output logic             rd_valid,
    output logic             skp_added,
    output logic             skp_removed
);
    logic          wr_en;
    logic [AW-1:0] wr_ptr;
    logic          half_tgl;
    logic          evt;
    logic [AW-1:0] rd_ptr;
    ebuf_ent_t     cur_ent, nxt_ent, out_ent, in_ent;

    assign in_ent = '{k: wr_kflag, d: wr_data};

    ebuf_wr_side #(.DEPTH(DEPTH)) u_wr (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_en    (wr_en),
        .wr_ptr   (wr_ptr),
        .half_tgl (half_tgl)
    );

    ebuf_store #(.DEPTH(DEPTH)) u_store (
        .wr_clk    (wr_clk),
        .wr_en     (wr_en),
        .wr_addr   (wr_ptr),
        .wr_ent    (in_ent),
        .rd_addr_a (rd_ptr),
        .rd_addr_b (rd_ptr + AW'(1)),
        .rd_ent_a  (cur_ent),
        .rd_ent_b  (nxt_ent)
    );

    ebuf_tgl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .tgl_in   (half_tgl),
        .evt      (evt)
    );

    ebuf_rd_ctrl #(
        .DEPTH     (DEPTH),
        .REF_PTR   (SYNC_STAGES),
        .BAND_HALF (BAND_HALF),
        .BAND_FULL (BAND_FULL)
    ) u_rd (
        .rd_clk    (rd_clk),
        .rd_rst_n  (rd_rst_n),
        .evt       (evt),
        .rate_full (rate_full),
        .cur_ent   (cur_ent),
        .nxt_ent   (nxt_ent),
        .rd_ptr    (rd_ptr),
        .out_ent   (out_ent),
        .out_vld   (rd_valid),
        .add_p     (skp_added),
        .rem_p     (skp_removed)
    );

    assign rd_data  = out_ent.d;
    assign rd_kflag = out_ent.k;
endmodule

// File: rtl/ebuf_half_full_chk.sv
module ebuf_half_full_chk
    import ebuf_pkg::*;
(
    input logic             rd_clk,
    input logic             rd_rst_n,
    input logic             rd_valid,
    input logic [ENT_W-1:0] rd_data,
    input logic [NSYM-1:0]  rd_kflag,
    input logic             skp_added,
    input logic             skp_removed
);
    ebuf_ent_t e;
    logic      adj_seen_q;

    assign e = '{k: rd_kflag, d: rd_data};

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            adj_seen_q <= 1'b0;
        end else if (rd_valid && ent_has_comma(e)) begin
            adj_seen_q <= 1'b0;
        end else if (skp_added || skp_removed) begin
            adj_seen_q <= 1'b1;
        end
    end

    // R10
    pulse_excl_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !(skp_added && skp_removed));

    // R9
    add_on_fill_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        skp_added |-> (rd_valid && ent_is_fill(e)));

    // R9
    add_repeat_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        skp_added |=> (rd_data == $past(rd_data) && rd_kflag == $past(rd_kflag)));

    // R8
    rem_keeps_fill_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        skp_removed |-> (rd_valid && ent_is_fill(e)));

    // R2
    valid_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_valid |=> rd_valid);

    // R7
    one_adj_per_set_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (skp_added || skp_removed) |-> !adj_seen_q);
endmodule

bind ebuf_half_full ebuf_half_full_chk u_chk (
    .rd_clk      (rd_clk),
    .rd_rst_n    (rd_rst_n),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .rd_kflag    (rd_kflag),
    .skp_added   (skp_added),
    .skp_removed (skp_removed)
);

// File: tb/ebuf_half_full_bench.sv
`timescale 1ns/1ps
module ebuf_half_full_bench;
    localparam real CLK_PERIOD = 4.0;
    localparam logic [9:0] COM_S  = 10'h0BC;
    localparam logic [9:0] FILL_S = 10'h01C;
    localparam logic [21:0] TAIL  = {2'b00, 10'h3FF, 10'h3FF};
    localparam logic [21:0] PRE   = {2'b00, 10'h3FE, 10'h3FE};

    logic        wr_clk = 1'b0, rd_clk = 1'b0;
    logic        wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic [19:0] wr_data = '0;
    logic [1:0]  wr_kflag = '0;
    logic        rate_full = 1'b0;
    logic [19:0] rd_data;
    logic [1:0]  rd_kflag;
    logic        rd_valid, skp_added, skp_removed;
    real         rd_per = CLK_PERIOD;

    int total = 0, bad = 0;
    logic [21:0] exp_q[$];
    int skp_in, skp_out, n_add, n_rem, first_add, rcyc, set_fill, set_adj;
    bit mon_on, synced, seen_set, prev_add;
    logic [21:0] prev_ent;
    int wd = 0;

    ebuf_half_full u_ebuf_half_full (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_data(wr_data), .wr_kflag(wr_kflag),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rate_full(rate_full),
        .rd_data(rd_data), .rd_kflag(rd_kflag), .rd_valid(rd_valid),
        .skp_added(skp_added), .skp_removed(skp_removed)
    );

    always #(CLK_PERIOD / 2.0) wr_clk = ~wr_clk;
    initial begin
        #1.3;
        forever #(rd_per / 2.0) rd_clk = ~rd_clk;
    end

    // Encoding per R3: flag bit 1 and low byte 0x1C / 0xBC
    function automatic bit is_fill(logic [21:0] v);
        return v[20] && v[7:0] == 8'h1C && v[21] && v[17:10] == 8'h1C;
    endfunction
    function automatic bit has_com(logic [21:0] v);
        return (v[20] && v[7:0] == 8'hBC) || (v[21] && v[17:10] == 8'hBC);
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge wr_clk) begin
        wd++;
        if (wd > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            finish_run();
        end
    end

    // monitor: pops expected entries as the design emits them
    always @(negedge rd_clk) begin
        if (mon_on && rd_rst_n) begin
            logic [21:0] e;
            rcyc++;
            e = {rd_kflag, rd_data};
            if (skp_added && skp_removed) check(0, "R10 both pulses", 1, 0);
            if (rd_valid) begin
                if (prev_add) check(e == prev_ent, "R9 repeat copy", e, prev_ent);
                prev_add = skp_added;
                prev_ent = e;
                if (skp_added) begin
                    n_add++; set_adj++;
                    if (first_add < 0) first_add = rcyc;
                end
                if (skp_removed) begin
                    n_rem++; set_adj++;
                end
                if (!synced && has_com(e)) synced = 1;
                if (synced) begin
                    if (is_fill(e)) begin
                        skp_out++; set_fill++;
                    end else if (e != TAIL) begin
                        if (has_com(e)) begin
                            if (seen_set) begin
                                check(set_fill >= 1, "R8 set keeps filler", set_fill, 1);
                                check(set_adj <= 1, "R7 one adjust per set", set_adj, 1);
                            end
                            set_fill = 0; set_adj = 0; seen_set = 1;
                        end
                        if (exp_q.size() == 0) check(0, "R1 unexpected entry", e, 0);
                        else begin
                            logic [21:0] x;
                            x = exp_q.pop_front();
                            check(e == x, "R1 data order", e, x);
                        end
                    end
                end
            end
        end
    end

    task automatic put(logic [21:0] v, bit push);
        @(negedge wr_clk);
        wr_kflag = v[21:20];
        wr_data  = v[19:0];
        if (push) exp_q.push_back(v);
    endtask

    task automatic drive(int nsets, bit short_sets);
        logic [9:0] c = 10'd0;
        for (int i = 0; i < 6; i++) put(PRE, 0);
        for (int s = 0; s < nsets; s++) begin
            put({2'b11, FILL_S, COM_S}, 1);
            for (int f = 0; f < (short_sets ? 1 : 2); f++) begin
                put({2'b11, FILL_S, FILL_S}, 0);
                skp_in++;
            end
            for (int d = 0; d < 13; d++) begin
                put({2'b00, c + 10'd1, c}, 1);
                c = c + 10'd2;
            end
        end
        put(TAIL, 0);
    endtask

    // mode: 0 equal, 1 fast read, 2 slow read
    task automatic run_case(real per, bit full, bit short_sets, int nsets, int mode, output int fa);
        wr_rst_n = 0; rd_rst_n = 0; mon_on = 0;
        wr_data = PRE[19:0]; wr_kflag = 2'b00;
        rd_per = per; rate_full = full;
        exp_q.delete();
        skp_in = 0; skp_out = 0; n_add = 0; n_rem = 0; first_add = -1; rcyc = 0;
        set_fill = 0; set_adj = 0; synced = 0; seen_set = 0; prev_add = 0;
        repeat (4) @(negedge wr_clk);
        wr_rst_n = 1; rd_rst_n = 1;
        @(negedge rd_clk);
        check(rd_valid == 0 && skp_added == 0 && skp_removed == 0, "R2 reset state",
              {rd_valid, skp_added, skp_removed}, 0);
        mon_on = 1;
        repeat (4) @(negedge wr_clk);
        check(rd_valid == 0, "R2 held before half fill", rd_valid, 0);
        drive(nsets, short_sets);
        for (int t = 0; t < 3000 && exp_q.size() != 0; t++) @(negedge rd_clk);
        repeat (4) @(negedge rd_clk);
        check(exp_q.size() == 0, "R1 all entries delivered", exp_q.size(), 0);
        check(skp_out == skp_in + n_add - n_rem, "R3 filler count balance", skp_out, skp_in + n_add - n_rem);
        case (mode)
            0: check(n_add == 0 && n_rem == 0, "R6 equal clocks untouched", n_add + n_rem, 0);
            1: check(n_add > 0 && n_rem == 0, "R4 fast read adds", {n_add[15:0], n_rem[15:0]}, 32'h0001_0000);
            default: begin
                if (short_sets) check(n_rem == 0, "R8 short sets not shortened", n_rem, 0);
                else check(n_rem > 0 && n_add == 0, "R5 slow read removes", {n_rem[15:0], n_add[15:0]}, 32'h0001_0000);
            end
        endcase
        fa = first_add;
    endtask

    initial begin
        int fa_half, fa_full, dummy;
        run_case(CLK_PERIOD, 0, 0, 12, 0, dummy);
        run_case(CLK_PERIOD, 1, 0, 12, 0, dummy);
        run_case(3.9, 0, 0, 30, 1, fa_half);
        run_case(3.9, 1, 0, 30, 1, fa_full);
        // R11: wider band in full-rate mode delays the first addition
        check(fa_half > 0 && fa_full > fa_half, "R11 band per mode", fa_full, fa_half);
        run_case(4.1, 0, 0, 30, 2, dummy);
        run_case(4.1, 0, 1, 10, 2, dummy);
        finish_run();
    end
endmodule